// File: doc/BRIEF.md
# Prescaled Serial Bit-Rate Tick Generator

This block is the timing source for one channel of an asynchronous serial port. It divides the input clock down to two strobes. The first is an oversampling strobe that the receiver and transmitter use to place their samples, and it fires sixteen times per bit. The second is a bit strobe that marks each bit boundary. Each channel gets its own instance, so channels can run at unrelated rates.

The divide ratio comes from two host-writable settings. The first is an 8-bit rate value N, from 0 to 255. The second is a 2-bit clock-select value n, from 0 to 3, which picks a power-of-four prescale. One bit lasts 32 × 4^n × (N+1) input clocks, and one oversampling interval lasts 2 × 4^n × (N+1) clocks. Both settings can be rewritten at any time. A write restarts the counting from a clean phase, so the period that follows has the new length from its first cycle. An enable input holds the counters cleared while it is low.

Top module: `sci_baud_gen`

## Requirements
- R1: A synchronous active-high reset sets the rate value to 255 and the clock-select value to 0, and drives both strobes low.
- R2: A write with `wr_addr`=0 stores `wr_data` as the rate value. A write with `wr_addr`=1 stores `wr_data[1:0]` as the clock-select value and ignores the upper data bits. Both stored values appear on `rate_val` and `sel_val` from the cycle after the write, and writes are accepted while the generator runs.
- R3: With enable high and no writes, `os_tick` pulses once every 2 × 4^n × (N+1) clock cycles, where n is the clock-select value (0..3) and N is the rate value.
- R4: `bit_tick` pulses on every sixteenth `os_tick`, in the same cycle as that pulse, giving a spacing of 32 × 4^n × (N+1) cycles.
- R5: While `en` is low, both strobes stay low and all counters stay cleared. Counting resumes at the first rising clock edge with `en` high. If that edge is edge 0, the first `os_tick` is high in the cycle after edge P−1, where P is the oversampling period.
- R6: A write of either setting clears all counters at its clock edge and suppresses the strobes. The first `os_tick` after it follows after one full period computed from the new settings.
- R7: Each strobe is high for exactly one clock cycle per pulse.
- R8: `bit_tick` is never high unless `os_tick` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the counters cleared |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the rate value, 1 selects the clock-select value |
| wr_data | input | 8 | Write data |
| rate_val | output | 8 | Stored rate value N |
| sel_val | output | 2 | Stored clock-select value n |
| os_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-boundary strobe, one cycle wide |

## Verification
The assertions assume that `rst` is asserted for at least one edge before any strobe matters. They also assume that the host inputs are stable around each clock edge, so a write is seen exactly once per `wr_en` cycle. The stimulus drives every input on the falling edge and holds `wr_en` for a single cycle per write. Some writes land in the middle of a running period and some during enable-low stretches, which exercises the restart rule against the per-cycle reference model. The period checks cover all four clock-select values, with N at 0, at 255 and at values in between.

// File: rtl/sci_baud_pkg.sv
package sci_baud_pkg;

  typedef enum logic {
    REG_RATE  = 1'b0,
    REG_CKSEL = 1'b1
  } reg_addr_e;

  // Number of input clocks per prescaler step for clock-select value k.
  function automatic int unsigned pre_len(input int unsigned k,
                                          input int unsigned base_log2,
                                          input int unsigned step_log2);
    return 32'd1 << (base_log2 + step_log2 * k);
  endfunction

endpackage

// File: rtl/sci_baud_regs.sv
module sci_baud_regs #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [DIV_W-1:0] div_next
);
  import sci_baud_pkg::*;

  logic div_we;
  logic sel_we;

  assign div_we   = wr_en && (reg_addr_e'(wr_addr) == REG_RATE);
  assign sel_we   = wr_en && (reg_addr_e'(wr_addr) == REG_CKSEL);
  assign div_next = div_we ? wr_data : div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '1;
      sel_q <= '0;
    end else begin
      if (div_we) div_q <= wr_data;
      if (sel_we) sel_q <= wr_data[SEL_W-1:0];
    end
  end

endmodule

// File: rtl/sci_baud_prescale.sv
module sci_baud_prescale #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 1,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_tick
);
  import sci_baud_pkg::*;

  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [PRE_W-1:0] last_cnt [NSEL];
  logic [PRE_W-1:0] pc;
  logic             at_end;

  for (genvar k = 0; k < NSEL; k++) begin : g_len
    localparam int unsigned LEN = pre_len(k, BASE_LOG2, STEP_LOG2);
    assign last_cnt[k] = PRE_W'(LEN - 1);
  end

  assign at_end   = (pc == last_cnt[sel]);
  assign pre_tick = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc <= '0;
    end else if (at_end) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

endmodule

// File: rtl/sci_baud_divider.sv
module sci_baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] load_val,
  output logic             os_fire
);

  logic [DIV_W-1:0] dc;

  assign os_fire = pre_tick && (dc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dc <= '1;
    end else if (!run) begin
      dc <= load_val;
    end else if (pre_tick) begin
      if (dc == '0) dc <= load_val;
      else          dc <= dc - 1'b1;
    end
  end

endmodule

// File: rtl/sci_baud_oscount.sv
module sci_baud_oscount #(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic os_fire,
  output logic bit_fire
);

  localparam int OC_W = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OS_RATE - 1);

  logic [OC_W-1:0] oc;

  assign bit_fire = os_fire && (oc == OC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      oc <= '0;
    end else if (os_fire) begin
      if (oc == OC_LAST) oc <= '0;
      else               oc <= oc + 1'b1;
    end
  end

endmodule

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 1,
  parameter int STEP_LOG2 = 2,
  parameter int OS_RATE   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] rate_val,
  output logic [SEL_W-1:0] sel_val,
  output logic             os_tick,
  output logic             bit_tick
);

  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_next;
  logic             run;
  logic             pre_tick;
  logic             os_fire;
  logic             bit_fire;

  // A write restarts every counter from a clean phase.
  assign run = en && !wr_en;

  sci_baud_regs #(.DIV_W(DIV_W), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_q(div_q), .sel_q(sel_q), .div_next(div_next)
  );

  sci_baud_prescale #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2),
                      .STEP_LOG2(STEP_LOG2)) pre_i (
    .clk(clk), .rst(rst), .run(run), .sel(sel_q), .pre_tick(pre_tick)
  );

  sci_baud_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .run(run), .pre_tick(pre_tick),
    .load_val(div_next), .os_fire(os_fire)
  );

  sci_baud_oscount #(.OS_RATE(OS_RATE)) osc_i (
    .clk(clk), .rst(rst), .run(run), .os_fire(os_fire), .bit_fire(bit_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= run && os_fire;
      bit_tick <= run && bit_fire;
    end
  end

  assign rate_val = div_q;
  assign sel_val  = sel_q;

endmodule

// File: rtl/sci_baud_gen_chk.sv
module sci_baud_gen_chk #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [DIV_W-1:0] wr_data,
  input logic [DIV_W-1:0] rate_val,
  input logic [SEL_W-1:0] sel_val,
  input logic             os_tick,
  input logic             bit_tick
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rate_val == '1 && sel_val == '0 && !os_tick && !bit_tick)); // R1

  AST_RATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (rate_val == $past(wr_data))); // R2

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> (sel_val == $past(wr_data[SEL_W-1:0]))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!os_tick && !bit_tick)); // R5

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!os_tick && !bit_tick)); // R6

  AST_OS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick); // R7

  AST_BIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R7

  AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick); // R8

endmodule

bind sci_baud_gen sci_baud_gen_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rate_val(rate_val), .sel_val(sel_val),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/sci_baud_gen_tb_top.sv
`timescale 1ns/1ps
module sci_baud_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rate_val;
  logic [1:0] sel_val;
  logic       os_tick;
  logic       bit_tick;

  always #2.5 clk = ~clk;

  sci_baud_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rate_val(rate_val), .sel_val(sel_val),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;
  bit     started = 1'b0;

  // behavioural reference model
  longint cyc = 0;
  longint phase = 0;
  int     m_div = 255;
  int     m_sel = 0;
  longint per = 512;
  bit     e_os = 1'b0;
  bit     e_bit = 1'b0;
  string  e_tag = "R1";
  bit     first_pend = 1'b0;
  string  first_tag = "R5";
  longint start_cyc = 0;
  bit     os_clean = 1'b0;
  bit     bit_clean = 1'b0;
  longint last_os = 0;
  longint last_bit = 0;
  bit     prev_os = 1'b0;
  bit     prev_bit = 1'b0;

  function automatic longint os_period(input int d, input int s);
    return 2 * (64'd1 << (2 * s)) * (d + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
               tag, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1'b1;
    if (rst) begin
      m_div = 255; m_sel = 0; phase = 0;
      e_os = 0; e_bit = 0; e_tag = "R1";
      first_pend = 0; os_clean = 0; bit_clean = 0;
    end else if (wr_en) begin
      if (wr_addr) m_sel = int'(wr_data[1:0]);
      else         m_div = int'(wr_data);
      phase = 0; e_os = 0; e_bit = 0; e_tag = "R6";
      first_pend = 1; first_tag = "R6"; start_cyc = cyc;
      os_clean = 0; bit_clean = 0;
    end else if (!en) begin
      phase = 0; e_os = 0; e_bit = 0; e_tag = "R5";
      first_pend = 1; first_tag = "R5"; start_cyc = cyc;
      os_clean = 0; bit_clean = 0;
    end else begin
      phase++;
      per = os_period(m_div, m_sel);
      e_os  = (phase % per) == 0;
      e_bit = (phase % (16 * per)) == 0;
      e_tag = "R3";
    end
    per = os_period(m_div, m_sel);
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(os_tick == e_os, e_tag, "os_tick", os_tick, e_os);
      check(bit_tick == e_bit, (e_tag == "R3") ? "R4" : e_tag, "bit_tick",
            bit_tick, e_bit);
      check(rate_val == m_div[7:0], rst ? "R1" : "R2", "rate_val",
            rate_val, m_div);
      check(sel_val == m_sel[1:0], rst ? "R1" : "R2", "sel_val",
            sel_val, m_sel);
      if (bit_tick) check(os_tick, "R8", "os_tick beside bit_tick", os_tick, 1);
      if (os_tick) begin
        check(!prev_os, "R7", "os_tick width", 2, 1);
        if (first_pend) begin
          check(cyc - start_cyc == per, first_tag, "first os spacing",
                cyc - start_cyc, per);
          first_pend = 0;
        end
        if (os_clean)
          check(cyc - last_os == per, "R3", "os spacing", cyc - last_os, per);
        last_os = cyc; os_clean = 1;
      end
      if (bit_tick) begin
        check(!prev_bit, "R7", "bit_tick width", 2, 1);
        if (bit_clean)
          check(cyc - last_bit == 16 * per, "R4", "bit spacing",
                cyc - last_bit, 16 * per);
        last_bit = cyc; bit_clean = 1;
      end
      prev_os = os_tick;
      prev_bit = bit_tick;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    // R1: reset state observed through the ports
    check(rate_val == 8'hFF, "R1", "rate_val after reset", rate_val, 255);
    check(sel_val == 2'd0, "R1", "sel_val after reset", sel_val, 0);
    check(!os_tick && !bit_tick, "R1", "strobes after reset",
          os_tick + bit_tick, 0);
    idle(10);
    en = 1'b1;                       // R5: first tick after enable
    idle(8600);                      // n=0, N=255: P=512, bit 8192
    wr(1'b0, 8'd0);                  // R2/R6: N=0, P=2
    idle(200);
    wr(1'b1, 8'd1);                  // n=1, N=0: P=8
    idle(300);
    wr(1'b1, 8'hFE);                 // R2: upper bits ignored, n=2
    wr(1'b0, 8'd2);                  // N=2: P=96, bit 1536
    idle(3200);
    wr(1'b1, 8'd3);
    wr(1'b0, 8'd0);                  // n=3, N=0: P=128, bit 2048
    idle(4300);
    wr(1'b1, 8'd1);
    wr(1'b0, 8'd5);                  // n=1, N=5: P=48
    idle(1000);
    en = 1'b0;                       // R5: quiet while disabled
    idle(60);
    wr(1'b0, 8'd3);                  // write while disabled
    idle(7);
    en = 1'b1;
    idle(700);
    for (int i = 0; i < 6; i++) begin // R6: writes mid-period
      idle(17 + 13 * i);
      wr(1'b0, 8'(i + 1));
    end
    idle(400);
    wr(1'b1, 8'd0);                  // n=0, N=6: P=14, bit 224
    idle(600);
    wr(1'b1, 8'd3);
    wr(1'b0, 8'd255);                // n=3, N=255: P=32768
    idle(66000);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule